// File: doc/BRIEF.md
# Synchronized glitch-free clock stop controller

This block sits behind the frequency synthesizer of a system clock generator. It takes one fast internal timing clock and derives two clock groups from a shared divider. The processor group runs at half the timing clock rate and the peripheral-bus group at a quarter of it. One extra peripheral-bus output runs freely. Each output is gated by a per-output enable bit from the configuration registers. The processor group and the peripheral-bus group can each be halted by an asynchronous active-low stop request. Every gate opens and closes only while its source clock is low, so an output is never cut off in a high phase and never starts with a short high pulse.

A mode strap is captured while reset is held. In mobile mode (strap 0), the two shared pins act as the stop inputs, and the highest-index peripheral-bus output is parked low because its pin is in use as an input. In desktop mode (strap 1), the stop requests are ignored and that output runs like the others.

Each clock group is steered by a two-state machine with the states HALT and RUN. The transition "resume" (HALT to RUN) is taken when the group's update point arrives and the synchronized request says run. The transition "halt" (RUN to HALT) is taken when the update point arrives and the request says stop. Reset forces HALT. The processor group's update point is every timing edge that brings its clock low. The peripheral-bus group's update point is only the falling edge of its clock. The gate register of each output is loaded at the same update point, with the output's enable bit if the next state is RUN and with 0 otherwise.

Top module: `clkstop_ctrl`

## Requirements
- R1: A gated output only goes low at the end of a complete high phase. A processor output's high phase always lasts exactly one timing clock cycle, and a peripheral-bus output's high phase, including the free-running one, always lasts exactly two. A stopped output sits at 0.
- R2: After a stop is lifted, the first high pulse of each output is full width. It starts only on a rising edge of its source clock.
- R3: The processor stop request passes through a two-stage synchronizer. Outputs stop within 8 timing cycles (4 processor clocks) of the request going low. The first high phase after the request goes high appears within 7 timing cycles.
- R4: The peripheral-bus stop request passes through a two-stage synchronizer. The change then takes effect at the next falling edge of the peripheral-bus clock, which is within one peripheral-bus clock. Outputs stop within 8 timing cycles of the request going low. The first high phase after release appears within 8 timing cycles.
- R5: While either stop request is active, the free-running peripheral-bus output and the other group keep running.
- R6: The strap value present during reset selects the mode. In mode 0, both stop inputs act, and the highest-index peripheral-bus output (index NPCI-1) stays low. In mode 1, both stop inputs are ignored and that output runs.
- R7: An output whose enable bit (bit i of its group's mask, and the single free-output enable) is 0 stays low whatever the stop inputs do. The change takes effect at the group's next update point.
- R8: While reset is held, all outputs are 0, and both synchronizers are preset to the running state.
- R9: An enabled running processor output rises 8 times in any 16 timing cycles, and an enabled running peripheral-bus output rises 4 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock; all divided clocks derive from it |
| rst_n | input | 1 | Active-low reset; the mode strap is sampled while it is low |
| mode_strap | input | 1 | Board strap: 0 mobile (stop inputs active), 1 desktop |
| cpu_stop_n | input | 1 | Asynchronous active-low processor-group stop request |
| pci_stop_n | input | 1 | Asynchronous active-low peripheral-bus-group stop request |
| cpu_en | input | NCPU | Per-output enable mask of the processor group |
| pci_en | input | NPCI | Per-output enable mask of the peripheral-bus group |
| pci_free_en | input | 1 | Enable of the free-running peripheral-bus output |
| cpu_clk_o | output | NCPU | Gated processor-group clocks |
| pci_clk_o | output | NPCI | Gated peripheral-bus-group clocks |
| pci_free_o | output | 1 | Free-running peripheral-bus clock |

## Verification
The outputs change only on rising timing edges, and the bench samples them on falling edges, half a cycle later. Stop and release requests are driven on a falling edge. Two synchronizer edges then pass, and then up to one group period passes until the update point. For that reason the bench waits the full 8-cycle bound before it opens a counting window. The restart latency is checked by counting falling-edge samples until the first high. Enable changes become visible within one group period, so each mask is given 6 to 8 cycles to settle before a 16-cycle window counts rises against 8 or 4. Stop requests are swept across all four divider phases, and a continuous monitor checks the width of every high pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic {
        GS_HALT = 1'b0,
        GS_RUN  = 1'b1
    } grp_state_e;
endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] shreg_q;

    // preset to "running" so a stop is never seen during reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '1;
        end else begin
            shreg_q <= {shreg_q[STAGES-2:0], async_n};
        end
    end

    assign sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/clk_gate_grp.sv
module clk_gate_grp
    import clkstop_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,      // edge that leaves the source clock low
    input  logic         phase,    // current source clock level
    input  logic         run_req,  // synchronized run request
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_o
);
    grp_state_e   state_q, state_d;
    logic [N-1:0] gate_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: resume and halt, only at update points
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:  if (upd && !run_req) state_d = GS_HALT;
            GS_HALT: if (upd && run_req)  state_d = GS_RUN;
            default: state_d = GS_HALT;
        endcase
    end

    // output gates: loaded only when the source clock is going/staying low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (upd) begin
            gate_q <= (state_d == GS_RUN) ? en : '0;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign clk_o[i] = phase & gate_q[i];
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
    parameter int NCPU        = 4,
    parameter int NPCI        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_strap,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic [NCPU-1:0] cpu_en,
    input  logic [NPCI-1:0] pci_en,
    input  logic            pci_free_en,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic [NPCI-1:0] pci_clk_o,
    output logic            pci_free_o
);
    localparam int DIV_W = 2;
    localparam logic [NPCI-1:0] SHARED_MASK = {1'b1, {(NPCI-1){1'b0}}};

    logic [DIV_W-1:0] cnt_q;
    logic             desktop_q;
    logic             cpu_sync_n, pci_sync_n;
    logic             cpu_run, pci_run;
    logic             cpu_upd, pci_upd;
    logic [NPCI-1:0]  pci_en_eff;

    // shared divider: bit 0 is the processor clock, top bit the bus clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // strap capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desktop_q <= mode_strap;
        end
    end

    stop_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
        .clk(clk), .rst_n(rst_n), .async_n(cpu_stop_n), .sync_n(cpu_sync_n)
    );
    stop_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
        .clk(clk), .rst_n(rst_n), .async_n(pci_stop_n), .sync_n(pci_sync_n)
    );

    assign cpu_run    = desktop_q | cpu_sync_n;
    assign pci_run    = desktop_q | pci_sync_n;
    assign cpu_upd    = cnt_q[0];     // next edge brings processor clock low
    assign pci_upd    = &cnt_q;       // next edge is the bus clock falling edge
    assign pci_en_eff = desktop_q ? pci_en : (pci_en & ~SHARED_MASK);

    clk_gate_grp #(.N(NCPU)) u_cpu_grp (
        .clk(clk), .rst_n(rst_n), .upd(cpu_upd), .phase(cnt_q[0]),
        .run_req(cpu_run), .en(cpu_en), .clk_o(cpu_clk_o)
    );

    clk_gate_grp #(.N(NPCI)) u_pci_grp (
        .clk(clk), .rst_n(rst_n), .upd(pci_upd), .phase(cnt_q[DIV_W-1]),
        .run_req(pci_run), .en(pci_en_eff), .clk_o(pci_clk_o)
    );

    clk_gate_grp #(.N(1)) u_free_grp (
        .clk(clk), .rst_n(rst_n), .upd(pci_upd), .phase(cnt_q[DIV_W-1]),
        .run_req(1'b1), .en(pci_free_en), .clk_o(pci_free_o)
    );
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
    parameter int NCPU = 4,
    parameter int NPCI = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ph,
    input logic            pci_ph,
    input logic [NCPU-1:0] cpu_clk_o,
    input logic [NPCI-1:0] pci_clk_o,
    input logic            pci_free_o
);
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        p_cpu_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_clk_o[i] |=> !cpu_clk_o[i]);
        p_cpu_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_clk_o[i]) |-> cpu_ph);
    end

    for (genvar i = 0; i < NPCI; i++) begin : g_pci
        p_pci_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (pci_ph && $past(pci_ph)) |-> $stable(pci_clk_o[i]));
        p_pci_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pci_clk_o[i]) |=> pci_clk_o[i]);
        p_pci_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pci_clk_o[i]) |-> !pci_ph);
    end

    p_free_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_free_o) |=> pci_free_o);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r8: assert (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o);
        end
    end
endmodule

bind clkstop_ctrl clkstop_chk #(.NCPU(NCPU), .NPCI(NPCI)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ph(cnt_q[0]), .pci_ph(cnt_q[1]),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;
    localparam int NCPU = 4;
    localparam int NPCI = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_strap = 1'b0;
    logic            cpu_stop_n = 1'b1;
    logic            pci_stop_n = 1'b1;
    logic [NCPU-1:0] cpu_en = '1;
    logic [NPCI-1:0] pci_en = '1;
    logic            pci_free_en = 1'b1;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic            pci_free_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    clkstop_ctrl #(.NCPU(NCPU), .NPCI(NPCI)) dut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_en(cpu_en), .pci_en(pci_en), .pci_free_en(pci_free_en),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // rise counters and pulse-width monitor, sampled on falling edges
    logic            meas_on = 1'b0;
    int              cr [NCPU];
    int              pr [NPCI];
    int              fr;
    int              chl [NCPU];
    int              phl [NPCI];
    int              fhl;
    logic [NCPU-1:0] cprev = '0;
    logic [NPCI-1:0] pprev = '0;
    logic            fprev = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < NCPU; i++) begin
            if (meas_on && cpu_clk_o[i] && !cprev[i]) cr[i]++;
            if (cpu_clk_o[i]) chl[i]++;
            else begin
                if (chl[i] != 0) chk(chl[i] == 1, "R1 cpu high width", chl[i], 1);
                chl[i] = 0;
            end
        end
        for (int i = 0; i < NPCI; i++) begin
            if (meas_on && pci_clk_o[i] && !pprev[i]) pr[i]++;
            if (pci_clk_o[i]) phl[i]++;
            else begin
                if (phl[i] != 0) chk(phl[i] == 2, "R1 pci high width", phl[i], 2);
                phl[i] = 0;
            end
        end
        if (meas_on && pci_free_o && !fprev) fr++;
        if (pci_free_o) fhl++;
        else begin
            if (fhl != 0) chk(fhl == 2, "R1 free high width", fhl, 2);
            fhl = 0;
        end
        cprev = cpu_clk_o;
        pprev = pci_clk_o;
        fprev = pci_free_o;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure();
        for (int i = 0; i < NCPU; i++) cr[i] = 0;
        for (int i = 0; i < NPCI; i++) pr[i] = 0;
        fr = 0;
        meas_on = 1'b1;
        tick(16);
        meas_on = 1'b0;
    endtask

    // compare which outputs ran; running ones must show exactly the R9 rate
    task automatic expect_run(input logic [NCPU-1:0] ce, input logic [NPCI-1:0] pe,
                              input logic fe, input string req);
        logic [NCPU-1:0] ca;
        logic [NPCI-1:0] pa;
        bit rate_ok;
        rate_ok = 1'b1;
        for (int i = 0; i < NCPU; i++) begin
            ca[i] = (cr[i] != 0);
            if (cr[i] != 0 && cr[i] != 8) rate_ok = 1'b0;
        end
        for (int i = 0; i < NPCI; i++) begin
            pa[i] = (pr[i] != 0);
            if (pr[i] != 0 && pr[i] != 4) rate_ok = 1'b0;
        end
        if (fr != 0 && fr != 4) rate_ok = 1'b0;
        chk(ca == ce, {req, " cpu run mask"}, int'(ca), int'(ce));
        chk(pa == pe, {req, " pci run mask"}, int'(pa), int'(pe));
        chk((fr != 0) == fe, {req, " free run"}, fr, fe ? 4 : 0);
        chk(rate_ok, "R9 rise count", 0, 1);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        mode_strap = mode;
        tick(4);
        chk(cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o, "R8 reset low",
            int'({pci_free_o, pci_clk_o, cpu_clk_o}), 0);
        rst_n = 1'b1;
        tick(8);
    endtask

    localparam logic [NPCI-1:0] SHMASK = 6'b10_0000;

    initial begin
        int lat;
        // ---- mobile mode ----
        do_reset(1'b0);
        measure();
        expect_run('1, ~SHMASK, 1'b1, "R6 mobile shared low");

        // R7: processor enable sweep
        for (int m = 0; m < 16; m++) begin
            cpu_en = 4'(m);
            tick(6);
            measure();
            expect_run(4'(m), ~SHMASK, 1'b1, "R7 cpu mask");
        end
        cpu_en = '1;
        // R7 and R6: bus enable sweep, shared output stays low in mobile mode
        for (int m = 0; m < 64; m++) begin
            pci_en = 6'(m);
            tick(8);
            measure();
            expect_run('1, 6'(m) & ~SHMASK, 1'b1, "R7 pci mask");
        end
        pci_en = '1;
        tick(8);

        // R3/R5: processor stop at every divider phase
        for (int ph = 0; ph < 4; ph++) begin
            tick(ph + 1);
            cpu_stop_n = 1'b0;
            tick(8);
            measure();
            expect_run('0, ~SHMASK, 1'b1, "R3 R5 cpu stopped");
            cpu_stop_n = 1'b1;
            lat = 0;
            while (cpu_clk_o[0] !== 1'b1 && lat < 20) begin
                tick(1);
                lat++;
            end
            chk(lat <= 7, "R3 restart latency", lat, 7);
            tick(4);
            measure();
            expect_run('1, ~SHMASK, 1'b1, "R2 cpu resumed");
        end

        // R4/R5: bus stop at every divider phase
        for (int ph = 0; ph < 4; ph++) begin
            tick(ph + 1);
            pci_stop_n = 1'b0;
            tick(8);
            measure();
            expect_run('1, '0, 1'b1, "R4 R5 pci stopped");
            pci_stop_n = 1'b1;
            lat = 0;
            while (pci_clk_o[0] !== 1'b1 && lat < 20) begin
                tick(1);
                lat++;
            end
            chk(lat <= 8, "R4 restart latency", lat, 8);
            tick(4);
            measure();
            expect_run('1, ~SHMASK, 1'b1, "R2 pci resumed");
        end

        // R7: disabled output stays low across a stop and its release
        cpu_stop_n = 1'b0;
        tick(8);
        cpu_en = 4'b0101;
        cpu_stop_n = 1'b1;
        tick(10);
        measure();
        expect_run(4'b0101, ~SHMASK, 1'b1, "R7 enable over stop");
        cpu_en = '1;

        // R7: free output enable
        pci_free_en = 1'b0;
        tick(8);
        measure();
        expect_run('1, ~SHMASK, 1'b0, "R7 free disabled");
        pci_free_en = 1'b1;

        // ---- desktop mode: stop inputs ignored, shared output runs ----
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        do_reset(1'b1);
        measure();
        expect_run('1, '1, 1'b1, "R6 desktop");
        pci_stop_n = 1'b1;
        cpu_stop_n = 1'b1;
        tick(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule